// File: doc/BRIEF.md
# Control-Port Access Sequencer

This block turns one register command into the staged strobe traffic of a control-register port inside a physical-layer macro. The command side gives an offset, a write flag, 16 bits of write data and a start pulse. It gets back a one-cycle done pulse, a 2-bit result code and the 16-bit word read from the port. The port side is a shared 16-bit bus that carries either an address or a data word. Four strobes are used: address capture, data capture, write commit and read. A single acknowledge comes back from the port.

A read runs two stages: address capture, then read. A write runs three: address capture, data capture, then commit. Every stage is a full four-phase handshake. The bus is set up one cycle before the strobe rises. The strobe then stays high until the acknowledge rises. After the strobe drops, the sequencer waits for the acknowledge to fall before the next stage starts. Each of the two acknowledge waits has its own timeout. The limit is given in cycles, derived from the clock rate in MHz and a timeout in microseconds. The default is 200 MHz and 100 µs. Offsets past the top of the port's address space are refused before any port activity.

Top module: `ctlPortSeq`

## Requirements
- R1: A read with a valid offset raises `stbAddr` once, with the offset on `portBus`, and then raises `stbRead` once. `stbData` and `stbCommit` stay low.
- R2: A write with a valid offset raises `stbAddr` with the offset on `portBus`, then `stbData` with the write data on `portBus`, then `stbCommit`, each exactly once. The port register at that offset then holds the write data. `stbRead` stays low.
- R3: At most one strobe is high at a time. A strobe stays high until `portAck` is seen high. `portBus` does not change while a strobe is high. The next stage begins only after `portAck` is seen low.
- R4: `portRdata` is captured while `portAck` is high during the read stage. The captured word appears on `cmdRdata` when done pulses. It holds there until the next successful read.
- R5: An offset greater than 0x201F is refused. The done pulse comes in the first cycle after the start is sampled, with `cmdErr` = 2'b01. No strobe rises and `cmdRdata` is unchanged.
- R6: If `portAck` does not rise within TIMEOUT_CYC cycles of a strobe going high, the strobe is high for exactly TIMEOUT_CYC cycles. It then drops and done pulses with `cmdErr` = 2'b10.
- R7: If `portAck` does not fall within TIMEOUT_CYC cycles after a strobe drops, done pulses with `cmdErr` = 2'b10. No later stage of that command starts.
- R8: `cmdDone` is high for exactly one cycle per accepted command. A command that completes all its stages reports `cmdErr` = 2'b00.
- R9: A `cmdStart` that arrives while a command is in progress has no effect. That command gives no done pulse and raises no strobe.
- R10: After reset, `cmdDone`, `cmdErr`, `cmdRdata`, `portBus` and all strobes are zero.
- R11: After a timeout, a later command with a well-behaved acknowledge completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdStart | input | 1 | Start pulse for one command |
| cmdWrite | input | 1 | 1 = write, 0 = read |
| cmdOffset | input | 16 | Register offset |
| cmdWdata | input | 16 | Write data |
| cmdDone | output | 1 | One-cycle completion pulse |
| cmdErr | output | 2 | 00 ok, 01 bad offset, 10 acknowledge timeout |
| cmdRdata | output | 16 | Last word read |
| portBus | output | 16 | Shared address/data bus to the port |
| stbAddr | output | 1 | Address capture strobe |
| stbData | output | 1 | Data capture strobe |
| stbCommit | output | 1 | Write commit strobe |
| stbRead | output | 1 | Read strobe |
| portAck | input | 1 | Port acknowledge |
| portRdata | input | 16 | Read data from the port |

## Verification
Commands are tried against a port model whose acknowledge latency varies from zero to five cycles, so stage ordering cannot depend on a fixed response time. Reads are tried at offsets that alias the same model register as an earlier write, which shows that the address really reached the bus. The offsets 0x201F and 0x2020 separate the accept and refuse sides of the range check. An acknowledge that never rises and one that never falls exercise the two timeouts separately. A second start sent mid-command shows whether busy starts leak through.

// File: rtl/ctlPortPkg.sv
package ctlPortPkg;
  typedef enum logic [1:0] {
    ERR_OK      = 2'b00,
    ERR_RANGE   = 2'b01,
    ERR_TIMEOUT = 2'b10
  } errCode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_WAIT_HI,
    ST_WAIT_LO
  } seqState_e;

  typedef enum logic [1:0] {
    STG_ADDR,
    STG_DATA,
    STG_COMMIT,
    STG_READ
  } stage_e;

  typedef struct packed {
    logic loadOffset;
    logic loadWdata;
    logic capRead;
  } dpCtl_t;
endpackage

// File: rtl/ctlPortDatapath.sv
module ctlPortDatapath
  import ctlPortPkg::*;
#(
  parameter int DATA_W = 16,
  parameter logic [DATA_W-1:0] MAX_OFFSET = 16'h201F
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            dpCtl,
  input  logic [DATA_W-1:0] cmdOffset,
  input  logic [DATA_W-1:0] cmdWdata,
  input  logic [DATA_W-1:0] portRdata,
  output logic [DATA_W-1:0] portBus,
  output logic [DATA_W-1:0] cmdRdata,
  output logic              offsetBad
);
  logic [DATA_W-1:0] busQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] rdataQ;

  assign offsetBad = (cmdOffset > MAX_OFFSET);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busQ   <= '0;
      wdataQ <= '0;
      rdataQ <= '0;
    end else begin
      if (dpCtl.loadOffset) begin
        busQ   <= cmdOffset;
        wdataQ <= cmdWdata;
      end else if (dpCtl.loadWdata) begin
        busQ <= wdataQ;
      end
      if (dpCtl.capRead) rdataQ <= portRdata;
    end
  end

  assign portBus  = busQ;
  assign cmdRdata = rdataQ;

  AST_LOADS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({dpCtl.loadOffset, dpCtl.loadWdata, dpCtl.capRead})); // R3
endmodule

// File: rtl/ctlPortCtrl.sv
module ctlPortCtrl
  import ctlPortPkg::*;
#(
  parameter int TIMEOUT_CYC = 20000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdStart,
  input  logic       cmdWrite,
  input  logic       offsetBad,
  input  logic       portAck,
  output dpCtl_t     dpCtl,
  output logic       stbAddr,
  output logic       stbData,
  output logic       stbCommit,
  output logic       stbRead,
  output logic       cmdDone,
  output logic [1:0] cmdErr
);
  localparam int TMR_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(TIMEOUT_CYC - 1);

  seqState_e        stateQ, stateD;
  stage_e           stageQ, stageD;
  logic [TMR_W-1:0] timerQ, timerD;
  logic             isWrQ, isWrD;
  logic             doneQ, doneD;
  errCode_e         errQ, errD;
  logic             tmoHit;
  logic             stbOn;

  assign tmoHit = (timerQ == TMR_LAST);

  always_comb begin
    stateD = stateQ;
    stageD = stageQ;
    timerD = timerQ;
    isWrD  = isWrQ;
    doneD  = 1'b0;
    errD   = errQ;
    dpCtl  = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (cmdStart) begin
          if (offsetBad) begin
            doneD = 1'b1;
            errD  = ERR_RANGE;
          end else begin
            dpCtl.loadOffset = 1'b1;
            isWrD  = cmdWrite;
            stageD = STG_ADDR;
            stateD = ST_SETUP;
          end
        end
      end
      ST_SETUP: begin
        timerD = '0;
        stateD = ST_WAIT_HI;
      end
      ST_WAIT_HI: begin
        if (portAck) begin
          dpCtl.capRead = (stageQ == STG_READ);
          timerD = '0;
          stateD = ST_WAIT_LO;
        end else if (tmoHit) begin
          doneD  = 1'b1;
          errD   = ERR_TIMEOUT;
          stateD = ST_IDLE;
        end else begin
          timerD = timerQ + 1'b1;
        end
      end
      ST_WAIT_LO: begin
        if (!portAck) begin
          unique case (stageQ)
            STG_ADDR: begin
              stageD = isWrQ ? STG_DATA : STG_READ;
              dpCtl.loadWdata = isWrQ;
              stateD = ST_SETUP;
            end
            STG_DATA: begin
              stageD = STG_COMMIT;
              stateD = ST_SETUP;
            end
            default: begin
              doneD  = 1'b1;
              errD   = ERR_OK;
              stateD = ST_IDLE;
            end
          endcase
        end else if (tmoHit) begin
          doneD  = 1'b1;
          errD   = ERR_TIMEOUT;
          stateD = ST_IDLE;
        end else begin
          timerD = timerQ + 1'b1;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      stageQ <= STG_ADDR;
      timerQ <= '0;
      isWrQ  <= 1'b0;
      doneQ  <= 1'b0;
      errQ   <= ERR_OK;
    end else begin
      stateQ <= stateD;
      stageQ <= stageD;
      timerQ <= timerD;
      isWrQ  <= isWrD;
      doneQ  <= doneD;
      errQ   <= errD;
    end
  end

  assign stbOn     = (stateQ == ST_WAIT_HI);
  assign stbAddr   = stbOn && (stageQ == STG_ADDR);
  assign stbData   = stbOn && (stageQ == STG_DATA);
  assign stbCommit = stbOn && (stageQ == STG_COMMIT);
  assign stbRead   = stbOn && (stageQ == STG_READ);
  assign cmdDone   = doneQ;
  assign cmdErr    = errQ;

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stbAddr, stbData, stbCommit, stbRead})); // R3
  AST_STROBE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (stbOn && !portAck && !tmoHit) |=> stbOn); // R3
  AST_RANGE_REFUSE: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_IDLE && cmdStart && offsetBad) |=> (cmdDone && cmdErr == 2'b01 && !stbOn)); // R5
  AST_RISE_TIMEOUT: assert property (@(posedge clk) disable iff (!rstN)
    (stbOn && !portAck && tmoHit) |=> (cmdDone && cmdErr == 2'b10 && !stbOn)); // R6
  AST_FALL_TIMEOUT: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_WAIT_LO && portAck && tmoHit) |=> (cmdDone && cmdErr == 2'b10 && stateQ == ST_IDLE)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    cmdDone |=> !cmdDone); // R8
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ != ST_IDLE) |-> !dpCtl.loadOffset); // R9
endmodule

// File: rtl/ctlPortSeq.sv
module ctlPortSeq
  import ctlPortPkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int CLK_MHZ    = 200,
  parameter int TIMEOUT_US = 100,
  parameter logic [DATA_W-1:0] MAX_OFFSET = 16'h201F
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdStart,
  input  logic              cmdWrite,
  input  logic [DATA_W-1:0] cmdOffset,
  input  logic [DATA_W-1:0] cmdWdata,
  output logic              cmdDone,
  output logic [1:0]        cmdErr,
  output logic [DATA_W-1:0] cmdRdata,
  output logic [DATA_W-1:0] portBus,
  output logic              stbAddr,
  output logic              stbData,
  output logic              stbCommit,
  output logic              stbRead,
  input  logic              portAck,
  input  logic [DATA_W-1:0] portRdata
);
  localparam int TIMEOUT_CYC = CLK_MHZ * TIMEOUT_US;

  dpCtl_t dpCtl;
  logic   offsetBad;
  logic   anyStb;

  ctlPortCtrl #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .cmdWrite(cmdWrite),
    .offsetBad(offsetBad), .portAck(portAck), .dpCtl(dpCtl),
    .stbAddr(stbAddr), .stbData(stbData), .stbCommit(stbCommit), .stbRead(stbRead),
    .cmdDone(cmdDone), .cmdErr(cmdErr)
  );

  ctlPortDatapath #(.DATA_W(DATA_W), .MAX_OFFSET(MAX_OFFSET)) u_dp (
    .clk(clk), .rstN(rstN), .dpCtl(dpCtl), .cmdOffset(cmdOffset),
    .cmdWdata(cmdWdata), .portRdata(portRdata), .portBus(portBus),
    .cmdRdata(cmdRdata), .offsetBad(offsetBad)
  );

  assign anyStb = stbAddr | stbData | stbCommit | stbRead;

  AST_BUS_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (anyStb && $past(anyStb)) |-> $stable(portBus)); // R3
endmodule

// File: tb/ctlPortSeq_test.sv
`timescale 1ns/1ps
module ctlPortSeq_test;
  localparam int TCYC = 200;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdStart = 1'b0, cmdWrite = 1'b0;
  logic [15:0] cmdOffset = '0, cmdWdata = '0;
  logic cmdDone;
  logic [1:0] cmdErr;
  logic [15:0] cmdRdata, portBus, portRdata;
  logic stbAddr, stbData, stbCommit, stbRead;
  logic portAck;

  always #2.5 clk = ~clk;

  ctlPortSeq #(.TIMEOUT_US(1)) uut (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .cmdWrite(cmdWrite),
    .cmdOffset(cmdOffset), .cmdWdata(cmdWdata), .cmdDone(cmdDone),
    .cmdErr(cmdErr), .cmdRdata(cmdRdata), .portBus(portBus),
    .stbAddr(stbAddr), .stbData(stbData), .stbCommit(stbCommit),
    .stbRead(stbRead), .portAck(portAck), .portRdata(portRdata)
  );

  // Port model
  logic ackR;
  int   cnt, dly;
  bit   noRise, noFall;
  logic [15:0] addrL, dataL;
  logic [15:0] mem [16];
  wire  anyStb = stbAddr | stbData | stbCommit | stbRead;
  assign portAck   = ackR;
  assign portRdata = mem[addrL[3:0]];

  always @(posedge clk) begin
    if (!rstN) begin
      ackR <= 1'b0; cnt <= 0; addrL <= '0; dataL <= '0;
      for (int i = 0; i < 16; i++) mem[i] <= 16'hC000 + 16'(i);
    end else if (anyStb && !ackR) begin
      if (!noRise) begin
        if (cnt >= dly) begin
          ackR <= 1'b1; cnt <= 0;
          if (stbAddr) addrL <= portBus;
          if (stbData) dataL <= portBus;
          if (stbCommit) mem[addrL[3:0]] <= dataL;
        end else cnt <= cnt + 1;
      end
    end else if (!anyStb && ackR) begin
      if (!noFall) begin
        if (cnt >= dly) begin ackR <= 1'b0; cnt <= 0; end
        else cnt <= cnt + 1;
      end
    end else cnt <= 0;
  end

  // Observers
  int nA = 0, nD = 0, nC = 0, nR = 0, busGlitch = 0, doneCnt = 0, hiCnt = 0;
  logic pA = 0, pD = 0, pC = 0, pR = 0, pAny = 0;
  logic [15:0] pBus = '0;
  always @(posedge clk) begin
    if (stbAddr && !pA) nA++;
    if (stbData && !pD) nD++;
    if (stbCommit && !pC) nC++;
    if (stbRead && !pR) nR++;
    if (anyStb && pAny && portBus != pBus) busGlitch++;
    if (cmdDone) doneCnt++;
    pA <= stbAddr; pD <= stbData; pC <= stbCommit; pR <= stbRead;
    pAny <= anyStb; pBus <= portBus;
  end
  always @(negedge clk) if (anyStb) hiCnt++;

  int checks = 0, fails = 0;
  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  task automatic runCmd(input logic wr, input logic [15:0] off, input logic [15:0] wd,
                        output logic [1:0] err, output logic [15:0] rd, output int lat);
    @(negedge clk);
    cmdWrite = wr; cmdOffset = off; cmdWdata = wd; cmdStart = 1'b1;
    @(negedge clk);
    cmdStart = 1'b0;
    lat = 1;
    while (!cmdDone && lat < 3000) begin @(negedge clk); lat++; end
    err = cmdErr; rd = cmdRdata;
    @(negedge clk);
    check(!cmdDone, "R8 done single cycle", int'(cmdDone), 0);
  endtask

  typedef struct packed {
    logic wr; logic [15:0] off; logic [15:0] wd; logic [3:0] dl; logic [1:0] er; logic [15:0] rd;
  } vec_t;
  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 16'h0003, 16'hA5A5, 4'd0, 2'b00, 16'h0000},
    '{1'b0, 16'h0003, 16'h0000, 4'd0, 2'b00, 16'hA5A5},
    '{1'b1, 16'h201F, 16'h1234, 4'd3, 2'b00, 16'h0000},
    '{1'b0, 16'h201F, 16'h0000, 4'd3, 2'b00, 16'h1234},
    '{1'b0, 16'h0005, 16'h0000, 4'd1, 2'b00, 16'hC005},
    '{1'b1, 16'h2020, 16'hBEEF, 4'd0, 2'b01, 16'h0000},
    '{1'b0, 16'hFFFF, 16'h0000, 4'd0, 2'b01, 16'h0000},
    '{1'b0, 16'h0013, 16'h0000, 4'd2, 2'b00, 16'hA5A5},
    '{1'b1, 16'h0000, 16'h0F0F, 4'd5, 2'b00, 16'h0000},
    '{1'b0, 16'h1000, 16'h0000, 4'd0, 2'b00, 16'h0F0F}
  };

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    finishRun();
  end

  initial begin
    logic [1:0] err;
    logic [15:0] rd, prevRd;
    int lat, a0, d0, c0, r0, dn0, h0;
    dly = 0; noRise = 0; noFall = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(!cmdDone && cmdErr == 2'b00 && cmdRdata == 16'h0 && portBus == 16'h0 &&
          !anyStb, "R10 reset state", {cmdErr, cmdRdata}, 0);

    for (int v = 0; v < NV; v++) begin
      dly = int'(VECS[v].dl);
      a0 = nA; d0 = nD; c0 = nC; r0 = nR; dn0 = doneCnt; prevRd = cmdRdata;
      runCmd(VECS[v].wr, VECS[v].off, VECS[v].wd, err, rd, lat);
      check(err == VECS[v].er, "R8 result code", err, VECS[v].er);
      check(doneCnt - dn0 == 1, "R8 one done per command", doneCnt - dn0, 1);
      if (VECS[v].er != 2'b00) begin
        check(lat == 1, "R5 refusal latency", lat, 1);
        check(nA == a0 && nD == d0 && nC == c0 && nR == r0, "R5 no strobe",
              (nA - a0) + (nD - d0) + (nC - c0) + (nR - r0), 0);
        check(rd == prevRd, "R5 rdata unchanged", rd, prevRd);
      end else if (VECS[v].wr) begin
        check(nA - a0 == 1 && nD - d0 == 1 && nC - c0 == 1 && nR == r0,
              "R2 write strobes", {4'(nA - a0), 4'(nD - d0), 4'(nC - c0), 4'(nR - r0)}, 16'h1110);
      end else begin
        check(nA - a0 == 1 && nR - r0 == 1 && nD == d0 && nC == c0,
              "R1 read strobes", {4'(nA - a0), 4'(nD - d0), 4'(nC - c0), 4'(nR - r0)}, 16'h1001);
        check(rd == VECS[v].rd, "R4 read data", rd, VECS[v].rd);
      end
    end
    check(busGlitch == 0, "R3 bus stable under strobe", busGlitch, 0);

    // R9: start while busy is ignored
    dly = 5; a0 = nA; d0 = nD; c0 = nC; r0 = nR; dn0 = doneCnt;
    @(negedge clk);
    cmdWrite = 1'b0; cmdOffset = 16'h0005; cmdStart = 1'b1;
    @(negedge clk);
    cmdStart = 1'b0;
    repeat (3) @(negedge clk);
    cmdWrite = 1'b1; cmdOffset = 16'h0005; cmdWdata = 16'hDEAD; cmdStart = 1'b1;
    @(negedge clk);
    cmdStart = 1'b0;
    lat = 0;
    while (!cmdDone && lat < 3000) begin @(negedge clk); lat++; end
    check(cmdRdata == 16'hC005, "R9 busy read data", cmdRdata, 16'hC005);
    repeat (30) @(negedge clk);
    check(doneCnt - dn0 == 1, "R9 single done", doneCnt - dn0, 1);
    check(nD == d0 && nC == c0 && nA - a0 == 1 && nR - r0 == 1, "R9 no extra strobes",
          (nD - d0) + (nC - c0), 0);
    dly = 0;
    runCmd(1'b0, 16'h0005, 16'h0, err, rd, lat);
    check(rd == 16'hC005, "R9 register untouched", rd, 16'hC005);

    // R6: acknowledge never rises
    noRise = 1; h0 = hiCnt; r0 = nR;
    runCmd(1'b0, 16'h0001, 16'h0, err, rd, lat);
    check(err == 2'b10, "R6 rise timeout code", err, 2'b10);
    check(hiCnt - h0 == TCYC, "R6 strobe high cycles", hiCnt - h0, TCYC);
    check(!anyStb && nR == r0, "R6 strobes dropped", int'(anyStb), 0);
    noRise = 0;

    // R7: acknowledge never falls
    noFall = 1; d0 = nD; c0 = nC;
    runCmd(1'b1, 16'h0002, 16'h7777, err, rd, lat);
    check(err == 2'b10, "R7 fall timeout code", err, 2'b10);
    check(nD == d0 && nC == c0 && !anyStb, "R7 no later stage", (nD - d0) + (nC - c0), 0);
    noFall = 0;
    repeat (4) @(negedge clk);

    // R11: recovery
    runCmd(1'b0, 16'h0003, 16'h0, err, rd, lat);
    check(err == 2'b00 && rd == 16'hA5A5, "R11 recovery read", rd, 16'hA5A5);

    finishRun();
  end
endmodule